// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block lets an external I2C master read and write a bank of 256 eight-bit control registers. A second, parallel port gives the rest of the chip access to the same bank. SCL and SDA are synchronised and oversampled by the system clock. The block detects START, repeated START and STOP conditions. It answers one of two 7-bit device addresses, and a strap input selects which one.

A write transfer carries a subaddress byte, which loads the register pointer, followed by any number of data bytes. A read uses the combined format: a write-direction transfer sets the pointer, then a repeated START and the read address follow. After the first data byte, the pointer steps by one after every byte in either direction, and it wraps from 0xFF to 0x00. SDA is only ever pulled low through an output enable.

The bus clock may run at up to 400 kbit/s. The system clock must be several tens of times faster than SCL so that the edges of both bus lines are resolved.

Top module: `i2c_regbank_slave`

## Requirements
- R1: With `addr_sel` low, the block acknowledges address byte 0x42 (write) and 0x43 (read) and does not acknowledge 0x40.
- R2: With `addr_sel` high, the block acknowledges 0x40 (write) and 0x41 (read) and does not acknowledge 0x42.
- R3: After a non-matching address byte, the block drives no acknowledge and ignores all bytes until the next START; no register changes.
- R4: In a write (START, address with bit0=0, subaddress, data, STOP), the slave acknowledges the address, the subaddress and each data byte, and the data lands in the register at the subaddress.
- R5: Consecutive written data bytes go to consecutive registers.
- R6: In a combined read (write address, subaddress, repeated START, read address), the slave returns the register at the subaddress and then the registers that follow, one per master-acknowledged byte.
- R7: After a master not-acknowledge on a read byte, the slave releases SDA and stays released until the next START or STOP.
- R8: The register pointer wraps from 0xFF to 0x00 on both writes and reads.
- R9: A read transfer that has no preceding subaddress starts at the pointer left by the previous transfer, which is one past the last byte moved.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: The parallel port reads the same bank combinationally and writes to it. A write from the parallel port is visible over I2C.
- R12: A repeated START in the middle of a write starts a new address phase. The next byte after the acknowledged address is taken as a fresh subaddress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | When 1, pull SDA low (open drain) |
| addr_sel | input | 1 | Strap: 0 selects address 0x21, 1 selects 0x20 |
| side_addr | input | 8 | Parallel-port register index |
| side_we | input | 1 | Parallel-port write strobe |
| side_wdata | input | 8 | Parallel-port write data |
| side_rdata | output | 8 | Register contents at `side_addr` |

## Verification
A corrupted pointer shows up one byte later, either as a read byte from the wrong register or as a written value that appears at a neighbouring index on the parallel port. A wrong protocol state shows up within one bit time, as a missing or spurious acknowledge, or as SDA held low after a master not-acknowledge or a mismatched address. A transmit shift that is off by one shows up as a rotated byte on the very first read.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h21,
  parameter logic [6:0] ALT_ADDR = 7'h20,
  parameter int         NREG     = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  input  logic [7:0] side_addr,
  input  logic       side_we,
  input  logic [7:0] side_wdata,
  output logic [7:0] side_rdata
);
  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_SUB = 4'd3, S_SACK = 4'd4,
    S_WDAT = 4'd5, S_WACK = 4'd6, S_RDAT = 4'd7, S_MACK = 4'd8
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] shreg, txsh, ptr;
  logic       rw, mack_ok;
  logic [7:0] mem [NREG];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire [6:0] my_addr = addr_sel ? ALT_ADDR : DEV_ADDR;
  wire [7:0] ptr_nx  = ptr + 8'd1;
  wire byte_in = scl_fall && cnt == 4'd8;
  wire wr_hit  = st == S_WDAT && byte_in && !start_c && !stop_c;

  assign side_rdata = mem[side_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; shreg <= '0; txsh <= '0; ptr <= '0;
      rw <= 1'b0; mack_ok <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_SUB, S_WDAT:
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_in) begin
            cnt <= '0;
            if (st == S_ADDR) begin
              if (shreg[7:1] == my_addr) begin
                rw <= shreg[0]; sda_oe <= 1'b1; st <= S_AACK;
              end else st <= S_IDLE;
            end else if (st == S_SUB) begin
              ptr <= shreg; sda_oe <= 1'b1; st <= S_SACK;
            end else begin
              ptr <= ptr_nx; sda_oe <= 1'b1; st <= S_WACK;
            end
          end
        S_AACK:
          if (scl_fall) begin
            if (rw) begin
              txsh <= mem[ptr]; sda_oe <= ~mem[ptr][7]; st <= S_RDAT;
            end else begin
              sda_oe <= 1'b0; st <= S_SUB;
            end
          end
        S_SACK, S_WACK:
          if (scl_fall) begin
            sda_oe <= 1'b0; st <= S_WDAT;
          end
        S_RDAT:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              cnt <= '0; sda_oe <= 1'b0; st <= S_MACK;
            end else begin
              sda_oe <= ~txsh[6]; txsh <= {txsh[6:0], 1'b0};
            end
          end
        S_MACK:
          if (scl_rise) mack_ok <= ~sda_s;
          else if (scl_fall) begin
            ptr <= ptr_nx;
            if (mack_ok) begin
              txsh <= mem[ptr_nx]; sda_oe <= ~mem[ptr_nx][7]; st <= S_RDAT;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_hit) mem[ptr] <= shreg;
    else if (side_we)    mem[side_addr] <= side_wdata;
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [3:0] st,
  input logic       start_c
);
  localparam logic [3:0] ST_IDLE = 4'd0;
  localparam logic [3:0] ST_MACK = 4'd8;

  // R10
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R7
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_oe);
  // R12
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .st(st), .start_c(start_c)
);

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
module tb_i2c_regbank_slave;
  localparam int Q = 25;
  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda_low = 0;
  logic addr_sel = 0, side_we = 0;
  logic [7:0] side_addr = 0, side_wdata = 0;
  logic sda_oe;
  logic [7:0] side_rdata;
  wire sda_bus = !(m_sda_low | sda_oe);
  int nchk = 0, nerr = 0, viol = 0;
  bit done = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .side_addr(side_addr), .side_we(side_we),
    .side_wdata(side_wdata), .side_rdata(side_rdata));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      if (exp_q.size() == 0) chk("R6 unexpected byte", got_q.pop_front(), 8'hxx);
      else chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  // R10: SDA enable never moves while SCL is high on the bus
  logic prev_oe = 0;
  always @(posedge clk) begin
    if (rst_n && m_scl && sda_oe !== prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic wq; repeat (Q) @(posedge clk); #1; endtask
  task automatic b_start;  m_sda_low = 0; m_scl = 1; wq; m_sda_low = 1; wq; m_scl = 0; wq; endtask
  task automatic b_rstart; m_sda_low = 0; wq; m_scl = 1; wq; m_sda_low = 1; wq; m_scl = 0; wq; endtask
  task automatic b_stop;   m_sda_low = 1; wq; m_scl = 1; wq; m_sda_low = 0; wq; endtask
  task automatic wbit(input logic b); m_sda_low = !b; wq; m_scl = 1; wq; wq; m_scl = 0; wq; endtask
  task automatic rbit(output logic b); m_sda_low = 0; wq; m_scl = 1; wq; b = sda_bus; wq; m_scl = 0; wq; endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b); ack = !b;
  endtask
  task automatic rbyte(input logic ack);
    logic [7:0] d; logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    got_q.push_back(d);
    wbit(!ack);
  endtask
  task automatic expect_rd(string req, logic [7:0] v); exp_q.push_back(v); tag_q.push_back(req); endtask
  task automatic side_wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1 side_addr = a; side_wdata = d; side_we = 1;
    @(posedge clk); #1 side_we = 0;
  endtask
  task automatic side_chk(string req, logic [7:0] a, logic [7:0] e);
    side_addr = a; #1 chk(req, side_rdata, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic a;
    logic b;
    repeat (5) @(posedge clk); #1 rst_n = 1;
    repeat (5) @(posedge clk); #1;
    chk("reset sda_oe", {7'd0, sda_oe}, 8'h00);
    side_chk("reset bank", 8'h00, 8'h00);

    // R4 / R1 single write
    b_start; wbyte(8'h42, a); chk("R1 ack 0x42", {7'd0, a}, 8'h01);
    wbyte(8'h10, a); chk("R4 ack sub", {7'd0, a}, 8'h01);
    wbyte(8'hA5, a); chk("R4 ack data", {7'd0, a}, 8'h01);
    b_stop; side_chk("R4 reg 10", 8'h10, 8'hA5);

    // R5 burst write
    b_start; wbyte(8'h42, a); wbyte(8'h20, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); b_stop;
    side_chk("R5 reg 20", 8'h20, 8'h11);
    side_chk("R5 reg 21", 8'h21, 8'h22);
    side_chk("R5 reg 22", 8'h22, 8'h33);

    // R6 combined read, R7 nack release
    b_start; wbyte(8'h42, a); wbyte(8'h20, a); b_rstart;
    wbyte(8'h43, a); chk("R1 ack 0x43", {7'd0, a}, 8'h01);
    expect_rd("R6 rd 20", 8'h11); expect_rd("R6 rd 21", 8'h22); expect_rd("R6 rd 22", 8'h33);
    rbyte(1); rbyte(1); rbyte(0);
    rbit(b); chk("R7 released after nack", {7'd0, b}, 8'h01);
    b_stop;

    // R9 read without subaddress continues at 0x23, R11 side write
    side_wr(8'h23, 8'h5C);
    b_start; wbyte(8'h43, a); expect_rd("R9 rd ptr 23", 8'h5C); rbyte(0); b_stop;

    // R8 wrap on write and read
    b_start; wbyte(8'h42, a); wbyte(8'hFF, a); wbyte(8'h77, a); wbyte(8'h88, a); b_stop;
    side_chk("R8 wr FF", 8'hFF, 8'h77);
    side_chk("R8 wr wrap 00", 8'h00, 8'h88);
    b_start; wbyte(8'h42, a); wbyte(8'hFF, a); b_rstart; wbyte(8'h43, a);
    expect_rd("R8 rd FF", 8'h77); expect_rd("R8 rd wrap 00", 8'h88);
    rbyte(1); rbyte(0); b_stop;

    // R3 / R1 wrong address ignored
    b_start; wbyte(8'h40, a); chk("R1 nack 0x40", {7'd0, a}, 8'h00);
    wbyte(8'h30, a); chk("R3 no ack after miss", {7'd0, a}, 8'h00);
    wbyte(8'h99, a); b_stop;
    side_chk("R3 reg 30 untouched", 8'h30, 8'h00);

    // R2 strap selects alternate address
    addr_sel = 1;
    b_start; wbyte(8'h42, a); chk("R2 nack 0x42", {7'd0, a}, 8'h00); b_stop;
    b_start; wbyte(8'h40, a); chk("R2 ack 0x40", {7'd0, a}, 8'h01);
    wbyte(8'h31, a); wbyte(8'h4E, a); b_stop;
    side_chk("R2 reg 31", 8'h31, 8'h4E);
    b_start; wbyte(8'h40, a); wbyte(8'h31, a); b_rstart;
    wbyte(8'h41, a); chk("R2 ack 0x41", {7'd0, a}, 8'h01);
    expect_rd("R2 rd 31", 8'h4E); rbyte(0); b_stop;
    addr_sel = 0;

    // R11 side write seen over I2C
    side_wr(8'h50, 8'hC3);
    b_start; wbyte(8'h42, a); wbyte(8'h50, a); b_rstart; wbyte(8'h43, a);
    expect_rd("R11 rd 50", 8'hC3); rbyte(0); b_stop;

    // R12 repeated START inside a write
    b_start; wbyte(8'h42, a); wbyte(8'h60, a); wbyte(8'h01, a); b_rstart;
    wbyte(8'h42, a); chk("R12 ack after Sr", {7'd0, a}, 8'h01);
    wbyte(8'h70, a); wbyte(8'h02, a); b_stop;
    side_chk("R12 reg 60", 8'h60, 8'h01);
    side_chk("R12 reg 70", 8'h70, 8'h02);
    side_chk("R12 reg 61 untouched", 8'h61, 8'h00);

    repeat (10) @(posedge clk);
    chk("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
    chk("R10 sda change while SCL high", 8'(viol), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule